// File: doc/BRIEF.md
# MSB-Justified Stereo Audio Serial Port

This block is the slave side of a stereo audio serial link for a 16-bit codec. The frame clock, the bit clock and the serial data input come from an external master. The block samples them with its own system clock and finds their edges there. On the receive side it assembles a left and a right word from the data input and presents them as one parallel pair with a single-cycle valid strobe. On the transmit side it takes a parallel pair from the converter and shifts it out on the data output.

Each half-frame carries one 16-bit two's-complement word. The word is sent most significant bit first, and that bit sits directly against the frame-clock edge with no delay slot. The frame clock is high for the left half and low for the right half. A half-frame may hold any number of bit slots from 16 upward. Slots after the sixteenth carry no information.

A force-zero input from the power and reset sequencer silences the transmit data. While it is active, the output reads as the value 0x0000.

Top module: `sj_audio_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sdout_o` and `dac_valid_o` are 0. After reset, `dac_left_o` and `dac_right_o` read 0x0000.
- R2: Received bits are taken on bit-clock rising edges, most significant bit first. The word of the half with `fclk_i`=1 goes to `dac_left_o` and the word of the half with `fclk_i`=0 goes to `dac_right_o`. `dac_valid_o` pulses for exactly one cycle after the 16th bit of the right word, and the pair is updated in that same cycle.
- R3: Bit slots after the 16th in a half-frame are ignored. Data ones sent in those slots do not change either received word, and the internal bit count never passes 16.
- R4: Half-frames of 16, 24 and 32 bit slots (frames of 32, 48 and 64 bit clocks) all work the same way.
- R5: A frame-clock edge that arrives before 16 bits have been received drops the partial word. No valid strobe is produced for that frame, and the outputs keep the previous pair. The next complete frame is received correctly.
- R6: The transmit word's most significant bit is driven from the frame-clock edge, and each later bit follows a bit-clock falling edge. The left word is sent while `fclk_i`=1 and the right word while `fclk_i`=0. Both words come from the `adc_left_i`/`adc_right_i` values sampled at the left frame edge, so a later change of the inputs does not affect the right word of that frame.
- R7: After its 16 data bits, the data output is 0 for the rest of the half-frame.
- R8: One cycle after `force_zero_i` goes high, `sdout_o` is 0 and stays 0 while it remains high, so a whole frame sent under force reads 0x0000/0x0000. Full-scale words 0x7FFF and 0x8000 and the silent word 0x0000 pass through unchanged when force is low.
- R9: When a frame-clock edge and a bit-clock falling edge are detected in the same cycle, the new word is loaded and the shift is skipped.
- R10: When a frame-clock edge and a bit-clock rising edge are detected in the same cycle, the bit counter restarts and the sampled bit is taken as the most significant bit of the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock from the master |
| fclk_i | input | 1 | Frame clock, 1 = left half-frame |
| sdin_i | input | 1 | Serial data in, DAC samples |
| sdout_o | output | 1 | Serial data out, ADC samples |
| force_zero_i | input | 1 | Sequencer request to send silence |
| adc_left_i | input | 16 | Parallel left ADC word to transmit |
| adc_right_i | input | 16 | Parallel right ADC word to transmit |
| dac_left_o | output | 16 | Last received left word |
| dac_right_o | output | 16 | Last received right word |
| dac_valid_o | output | 1 | One-cycle strobe for a new received pair |

## Verification
Because all three serial lines are oversampled, a frame-clock edge can be detected in the same system cycle as a bit-clock edge. On the transmit side, the bench provokes this in every frame: it moves the frame clock together with the falling bit clock, and it judges the result by the most significant bit being present when the receiver samples the first slot. On the receive side, it moves the frame clock together with a rising bit clock in a separate frame, and it judges the result by a correct pair arriving with one strobe. Short half-frames check that a frame edge restarting the counter drops partial words and suppresses the strobe.

// File: rtl/sj_pkg.sv
package sj_pkg;

    parameter int unsigned SJ_WORD_W = 16;

    // Per-cycle events seen on the oversampled serial lines
    typedef struct packed {
        logic bit_rise;
        logic bit_fall;
        logic frame_edge;
        logic left_half;
        logic data;
    } sj_evt_t;

    typedef struct packed {
        logic bclk;
        logic fclk;
        logic sdin;
    } sj_lines_t;

    function automatic sj_evt_t sj_decode(input sj_lines_t now, input sj_lines_t prev);
        sj_evt_t e;
        e.bit_rise   = now.bclk & ~prev.bclk;
        e.bit_fall   = ~now.bclk & prev.bclk;
        e.frame_edge = now.fclk ^ prev.fclk;
        e.left_half  = now.fclk;
        e.data       = now.sdin;
        return e;
    endfunction

endpackage

// File: rtl/sj_edge.sv
module sj_edge
    import sj_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bclk_i,
    input  logic    fclk_i,
    input  logic    sdin_i,
    output sj_evt_t ev_o
);
    sj_lines_t cur_q, old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            old_q <= '0;
        end else begin
            cur_q <= '{bclk: bclk_i, fclk: fclk_i, sdin: sdin_i};
            old_q <= cur_q;
        end
    end

    assign ev_o = sj_decode(cur_q, old_q);
endmodule

// File: rtl/sj_rx.sv
module sj_rx
    import sj_pkg::*;
#(
    parameter int W  = SJ_WORD_W,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  sj_evt_t       ev_i,
    output logic [W-1:0]  left_o,
    output logic [W-1:0]  right_o,
    output logic          valid_o,
    output logic [CW-1:0] bits_o
);
    logic [W-1:0]  shift_q, left_q;
    logic [W-1:0]  shift_nx;
    logic [CW-1:0] cnt_q;
    logic          left_ok_q;

    assign shift_nx = {shift_q[W-2:0], ev_i.data};
    assign bits_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q   <= '0;
            left_q    <= '0;
            cnt_q     <= '0;
            left_ok_q <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (ev_i.frame_edge) begin
                // restart; any partial word is dropped
                if (ev_i.left_half) left_ok_q <= 1'b0;
                if (ev_i.bit_rise) begin
                    shift_q <= shift_nx;
                    cnt_q   <= CW'(1);
                end else begin
                    cnt_q   <= '0;
                end
            end else if (ev_i.bit_rise && cnt_q < CW'(W)) begin
                shift_q <= shift_nx;
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == CW'(W - 1)) begin
                    if (ev_i.left_half) begin
                        left_q    <= shift_nx;
                        left_ok_q <= 1'b1;
                    end else if (left_ok_q) begin
                        left_o    <= left_q;
                        right_o   <= shift_nx;
                        valid_o   <= 1'b1;
                        left_ok_q <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sj_tx.sv
module sj_tx
    import sj_pkg::*;
#(
    parameter int W = SJ_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  sj_evt_t      ev_i,
    input  logic         force_i,
    input  logic [W-1:0] left_i,
    input  logic [W-1:0] right_i,
    output logic         sd_o
);
    logic [W-1:0] shift_q, hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            hold_q  <= '0;
            sd_o    <= 1'b0;
        end else begin
            if (ev_i.frame_edge) begin
                // load wins over a coincident falling edge
                if (ev_i.left_half) begin
                    shift_q <= force_i ? '0 : left_i;
                    hold_q  <= right_i;
                end else begin
                    shift_q <= force_i ? '0 : hold_q;
                end
            end else if (ev_i.bit_fall) begin
                shift_q <= {shift_q[W-2:0], 1'b0};
            end
            sd_o <= force_i ? 1'b0 : shift_q[W-1];
        end
    end
endmodule

// File: rtl/sj_audio_port.sv
module sj_audio_port
    import sj_pkg::*;
#(
    parameter int W  = SJ_WORD_W,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bclk_i,
    input  logic         fclk_i,
    input  logic         sdin_i,
    output logic         sdout_o,
    input  logic         force_zero_i,
    input  logic [W-1:0] adc_left_i,
    input  logic [W-1:0] adc_right_i,
    output logic [W-1:0] dac_left_o,
    output logic [W-1:0] dac_right_o,
    output logic         dac_valid_o
);
    sj_evt_t       ev;
    logic [CW-1:0] rx_bits;

    sj_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .bclk_i (bclk_i),
        .fclk_i (fclk_i),
        .sdin_i (sdin_i),
        .ev_o   (ev)
    );

    sj_rx #(.W(W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .left_o  (dac_left_o),
        .right_o (dac_right_o),
        .valid_o (dac_valid_o),
        .bits_o  (rx_bits)
    );

    sj_tx #(.W(W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .force_i (force_zero_i),
        .left_i  (adc_left_i),
        .right_i (adc_right_i),
        .sd_o    (sdout_o)
    );
endmodule

// File: rtl/sj_audio_port_chk.sv
module sj_audio_port_chk #(
    parameter int W  = 16,
    localparam int CW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          sdout_o,
    input logic          force_zero_i,
    input logic          dac_valid_o,
    input logic [CW-1:0] rx_bits
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!dac_valid_o && !sdout_o));

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dac_valid_o |=> !dac_valid_o);

    // R5
    full_word_chk: assert property (@(posedge clk) disable iff (rst)
        dac_valid_o |-> (rx_bits == CW'(W)));

    // R3
    bit_cap_chk: assert property (@(posedge clk) disable iff (rst)
        rx_bits <= CW'(W));

    // R8
    force_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $past(force_zero_i) |-> !sdout_o);
endmodule

bind sj_audio_port sj_audio_port_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sdout_o      (sdout_o),
    .force_zero_i (force_zero_i),
    .dac_valid_o  (dac_valid_o),
    .rx_bits      (rx_bits)
);

// File: tb/tb_sj_audio_port.sv
module tb_sj_audio_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, fclk = 1'b0, sdin = 1'b0, frc = 1'b0;
    logic [15:0] adc_l = '0, adc_r = '0;
    logic        sdout, dvalid;
    logic [15:0] dac_l, dac_r;

    int nchk = 0, nfail = 0, vcount = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sj_audio_port dut (
        .clk(clk), .rst(rst), .bclk_i(bclk), .fclk_i(fclk), .sdin_i(sdin),
        .sdout_o(sdout), .force_zero_i(frc), .adc_left_i(adc_l), .adc_right_i(adc_r),
        .dac_left_o(dac_l), .dac_right_o(dac_r), .dac_valid_o(dvalid)
    );

    always @(negedge clk) if (!rst && dvalid) vcount++;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one half-frame; early=1 moves the frame clock with the rising bit clock
    task automatic send_half(input logic [15:0] w, input int n, input bit lvl, input bit early,
                             output logic [15:0] txw, output int junk);
        txw = '0; junk = 0;
        for (int i = 0; i < n; i++) begin
            bclk = 1'b0;
            sdin = (i < 16) ? w[15-i] : 1'b1;
            if (i == 0 && !early) fclk = lvl;
            repeat (4) @(negedge clk);
            bclk = 1'b1;
            if (i == 0 && early) fclk = lvl;
            if (i < 16) txw[15-i] = sdout;
            else if (sdout) junk++;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        check(sdout == 1'b0 && dvalid == 1'b0, "R1 outputs in reset", {30'd0, sdout, dvalid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(dac_l == 16'h0 && dac_r == 16'h0, "R1 pair after reset", {dac_l, dac_r}, 0);
    endtask

    task automatic t_frame(input string tag, input logic [15:0] l, input logic [15:0] r,
                           input logic [15:0] al, input logic [15:0] ar, input int n);
        logic [15:0] tl, tr;
        int jl, jr, v0;
        v0 = vcount;
        adc_l = al; adc_r = ar;
        send_half(l, n, 1'b1, 1'b0, tl, jl);
        send_half(r, n, 1'b0, 1'b0, tr, jr);
        check(vcount == v0 + 1, {tag, " R2 one strobe"}, vcount - v0, 1);
        check(dac_l == l && dac_r == r, {tag, " R2 R3 R4 received pair"}, {dac_l, dac_r}, {l, r});
        check(tl == (frc ? 16'h0 : al) && tr == (frc ? 16'h0 : ar),
              {tag, " R6 R9 R8 sent pair"}, {tl, tr}, frc ? 0 : {al, ar});
        check(jl + jr == 0, {tag, " R7 idle slots low"}, jl + jr, 0);
    endtask

    task automatic t_short();
        logic [15:0] t;
        int j, v0;
        logic [15:0] pl, pr;
        v0 = vcount; pl = dac_l; pr = dac_r;
        send_half(16'h1357, 10, 1'b1, 1'b0, t, j);
        send_half(16'h2468, 16, 1'b0, 1'b0, t, j);
        check(vcount == v0, "R5 short left no strobe", vcount - v0, 0);
        check(dac_l == pl && dac_r == pr, "R5 pair kept", {dac_l, dac_r}, {pl, pr});
        send_half(16'h1357, 16, 1'b1, 1'b0, t, j);
        send_half(16'h2468, 9, 1'b0, 1'b0, t, j);
        check(vcount == v0, "R5 short right no strobe", vcount - v0, 0);
        t_frame("R5 recovery", 16'h0F0F, 16'hF00F, 16'h0102, 16'h0304, 16);
    endtask

    task automatic t_order();
        logic [15:0] tl, tr;
        int j;
        adc_l = 16'h1111; adc_r = 16'h2222;
        send_half(16'hAAAA, 16, 1'b1, 1'b0, tl, j);
        adc_l = 16'h3333; adc_r = 16'h4444;
        send_half(16'h5555, 16, 1'b0, 1'b0, tr, j);
        check(tl == 16'h1111 && tr == 16'h2222, "R6 pair taken at left edge", {tl, tr}, 32'h11112222);
    endtask

    task automatic t_force();
        frc = 1'b1;
        t_frame("R8 forced", 16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000, 24);
        check(sdout == 1'b0, "R8 line low under force", sdout, 0);
        frc = 1'b0;
        t_frame("R8 full scale", 16'h0000, 16'h7FFF, 16'h8000, 16'h7FFF, 16);
    endtask

    task automatic t_coincide();
        logic [15:0] t;
        int j, v0;
        v0 = vcount;
        send_half(16'hC3A5, 20, 1'b1, 1'b1, t, j);
        send_half(16'h5A3C, 20, 1'b0, 1'b1, t, j);
        check(vcount == v0 + 1, "R10 strobe on coincident edges", vcount - v0, 1);
        check(dac_l == 16'hC3A5 && dac_r == 16'h5A3C, "R10 pair on coincident edges",
              {dac_l, dac_r}, 32'hC3A55A3C);
    endtask

    initial begin
        t_reset();
        t_frame("R4 32-clock", 16'h1234, 16'h8000, 16'h7FFF, 16'h0000, 16);
        t_frame("R4 64-clock", 16'hA5A5, 16'h0001, 16'hBEEF, 16'h8001, 32);
        t_frame("R4 48-clock", 16'hFFFF, 16'h7FFF, 16'h00FF, 16'hFF00, 24);
        t_short();
        t_order();
        t_force();
        t_coincide();
        t_frame("R9 after coincide", 16'h4321, 16'h8765, 16'h2BAD, 16'hCAFE, 16);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule